// File: doc/BRIEF.md
# Ordered Store Buffer with Load Address Checking

This block holds every store that an out-of-order core has issued but not yet written to memory, kept in program order. A store takes a slot when it issues and carries the reorder-buffer tag of the instruction that will produce its value. Its address and its value come in later, separately and in either order. Each one is written by slot number. When the reorder buffer commits a store, the block marks it committed. The store at the head then goes to memory as soon as it is committed and both its address and its value are known.

A load hands over its address together with the queue position that it captured when it issued. The block looks only at stores older than that position and answers in the same cycle with one of four results. It stalls the load if any older store still lacks an address. It forwards the value when the youngest older store with the same address already holds its value. It returns that store's producer tag when the value is still missing. Otherwise it sends the load on to memory. A flush removes every store that has not yet been committed and keeps the committed ones, so those still drain.

Top module: `store_queue`

## Requirements
- R1: Stores are written to memory strictly oldest first. While `mem_wr_valid` is high, `mem_wr_addr` and `mem_wr_data` carry the oldest held store, and that store leaves the queue at the same clock edge.
- R2: A new store is taken when `alloc_valid` is high, the queue holds fewer than DEPTH stores and `flush` is low. `alloc_pos` gives the position it receives, which is the slot index plus one wrap bit above it. `alloc_ready` is low while DEPTH stores are held, and a request made then is dropped.
- R3: An address or value write names a slot and applies only if that slot holds a store. A write to an empty slot has no effect, including on a store that later takes that slot.
- R4: A load compares only against stores at positions older than its `ld_pos`. Stores at `ld_pos` or younger never affect its result.
- R5: If any older store still lacks its address, `ld_resp` is 1 (stall), whatever the other stores hold.
- R6: If a matching older store holds its value, `ld_resp` is 2 and `ld_data` is that value.
- R7: If the matching older store has no value yet, `ld_resp` is 3 and `ld_tag` is the producer tag given at allocation.
- R8: When several older stores match the load address, the youngest of them decides the result.
- R9: If no older store matches, or no older store exists, `ld_resp` is 0 (go to memory). `ld_resp` is also 0 while `ld_valid` is low.
- R10: Each `commit_valid` pulse marks the oldest uncommitted store as committed. A store is written to memory only once it is committed and holds both its address and its value.
- R11: `flush` removes all uncommitted stores, and `alloc_pos` falls back to the first uncommitted position. Committed stores stay and still drain. An allocation or commit requested in the same cycle is ignored.
- R12: Positions carry a wrap bit, so the age comparison and the full test stay correct after the pointers pass the end of the slot array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to take a new store slot |
| alloc_src_tag | input | TW | Reorder tag of the store value's producer |
| alloc_ready | output | 1 | Low while the queue is full |
| alloc_pos | output | PW+1 | Position given to the next allocation (slot plus wrap bit) |
| st_addr_valid | input | 1 | Writes an address into a slot |
| st_addr_slot | input | PW | Slot receiving the address |
| st_addr | input | AW | Store address |
| st_data_valid | input | 1 | Writes a value into a slot |
| st_data_slot | input | PW | Slot receiving the value |
| st_data | input | DW | Store value |
| commit_valid | input | 1 | Commits the oldest uncommitted store |
| flush | input | 1 | Removes all uncommitted stores |
| ld_valid | input | 1 | A load lookup is presented |
| ld_addr | input | AW | Load address |
| ld_pos | input | PW+1 | Queue position captured when the load issued |
| ld_resp | output | 2 | 0 memory, 1 stall, 2 forward value, 3 forward tag |
| ld_data | output | DW | Forwarded value when ld_resp is 2 |
| ld_tag | output | TW | Producer tag when ld_resp is 3 |
| mem_wr_valid | output | 1 | Head store is being written to memory this cycle |
| mem_wr_addr | output | AW | Address of that write |
| mem_wr_data | output | DW | Value of that write |

## Verification
A head, commit or tail pointer that is off by one shows up at once as a wrong `alloc_pos`. It also causes a memory write that is early, late or out of order, seen in the cycle after the commit pulse or the value arrival. A slot whose address or value flag is set or cleared wrongly changes the result of the next load whose window covers that slot. It turns a stall into a forward, or the reverse, in the same cycle as the lookup. Mistakes in the flush trim or the wrap bit appear as a wrong allocation position, or as a wrong window age for loads after the pointers wrap.

// File: rtl/stq_pkg.sv
package stq_pkg;
    typedef enum logic [1:0] {
        LD_GO_MEM   = 2'd0,
        LD_STALL    = 2'd1,
        LD_FWD_DATA = 2'd2,
        LD_FWD_TAG  = 2'd3
    } ld_resp_e;
endpackage

// File: rtl/stq_pointers.sv
// Head, commit and tail positions, each with a wrap bit above the slot index.
module stq_pointers #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        alloc_req,
    input  logic        commit_req,
    input  logic        flush,
    input  logic        drain_fire,
    output logic [PW:0] head,
    output logic [PW:0] cmt,
    output logic [PW:0] tail,
    output logic        full,
    output logic        alloc_fire
);
    typedef struct packed {
        logic [PW:0] head;
        logic [PW:0] cmt;
        logic [PW:0] tail;
    } ptr_state_t;

    ptr_state_t s_d, s_q;
    logic [PW:0] occ_q;
    logic        commit_fire;

    assign occ_q       = s_q.tail - s_q.head;
    assign full        = (occ_q == (PW+1)'(DEPTH));
    assign alloc_fire  = alloc_req & ~full & ~flush;
    assign commit_fire = commit_req & ~flush & (s_q.cmt != s_q.tail);

    always_comb begin
        s_d = s_q;
        if (drain_fire)  s_d.head = s_q.head + 1'b1;
        if (commit_fire) s_d.cmt  = s_q.cmt + 1'b1;
        if (flush)           s_d.tail = s_q.cmt;
        else if (alloc_fire) s_d.tail = s_q.tail + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head = s_q.head;
    assign cmt  = s_q.cmt;
    assign tail = s_q.tail;
endmodule

// File: rtl/stq_entries.sv
// Per-slot storage: valid, address/value known flags, address, value, producer tag.
module stq_entries #(
    parameter int DEPTH = 8,
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TW = 5,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_fire,
    input  logic [TW-1:0]                alloc_tag,
    input  logic                         addr_wr,
    input  logic [PW-1:0]                addr_slot,
    input  logic [AW-1:0]                addr_val,
    input  logic                         data_wr,
    input  logic [PW-1:0]                data_slot,
    input  logic [DW-1:0]                data_val,
    input  logic                         drain_fire,
    input  logic                         flush,
    input  logic [PW:0]                  head,
    input  logic [PW:0]                  cmt,
    input  logic [PW:0]                  tail,
    output logic [DEPTH-1:0]             addr_ok,
    output logic [DEPTH-1:0]             data_ok,
    output logic [DEPTH-1:0][AW-1:0]     addrs,
    output logic [DEPTH-1:0][DW-1:0]     datas,
    output logic [DEPTH-1:0][TW-1:0]     tags
);
    typedef struct packed {
        logic          valid;
        logic          aok;
        logic          dok;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [TW-1:0] tag;
    } ent_t;

    ent_t [DEPTH-1:0] e_d, e_q;
    logic [PW:0]      unc_cnt;

    assign unc_cnt = tail - cmt;

    always_comb begin
        e_d = e_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr_wr && addr_slot == PW'(i) && e_q[i].valid) begin
                e_d[i].addr = addr_val;
                e_d[i].aok  = 1'b1;
            end
            if (data_wr && data_slot == PW'(i) && e_q[i].valid) begin
                e_d[i].data = data_val;
                e_d[i].dok  = 1'b1;
            end
            if (drain_fire && head[PW-1:0] == PW'(i))
                e_d[i].valid = 1'b0;
            if (alloc_fire && tail[PW-1:0] == PW'(i)) begin
                e_d[i].valid = 1'b1;
                e_d[i].aok   = 1'b0;
                e_d[i].dok   = 1'b0;
                e_d[i].tag   = alloc_tag;
            end
            if (flush && ({1'b0, PW'(PW'(i) - cmt[PW-1:0])} < unc_cnt))
                e_d[i].valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign addr_ok[g] = e_q[g].aok;
        assign data_ok[g] = e_q[g].dok;
        assign addrs[g]   = e_q[g].addr;
        assign datas[g]   = e_q[g].data;
        assign tags[g]    = e_q[g].tag;
    end
endmodule

// File: rtl/stq_search.sv
// Combinational load lookup over the stores older than the load's position.
module stq_search
    import stq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TW = 5,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                     ld_valid,
    input  logic [AW-1:0]            ld_addr,
    input  logic [PW:0]              ld_pos,
    input  logic [PW:0]              head,
    input  logic [DEPTH-1:0]         addr_ok,
    input  logic [DEPTH-1:0]         data_ok,
    input  logic [DEPTH-1:0][AW-1:0] addrs,
    input  logic [DEPTH-1:0][DW-1:0] datas,
    input  logic [DEPTH-1:0][TW-1:0] tags,
    output ld_resp_e                 resp,
    output logic [DW-1:0]            fwd_data,
    output logic [TW-1:0]            fwd_tag
);
    logic [PW:0]   older_cnt;
    logic          stall;
    logic          hit;
    logic [PW-1:0] hit_idx;
    logic [PW-1:0] idx;

    assign older_cnt = ld_pos - head;

    // Walk from oldest to youngest; a later hit overwrites, so the youngest wins.
    always_comb begin
        stall   = 1'b0;
        hit     = 1'b0;
        hit_idx = '0;
        idx     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head[PW-1:0] + PW'(k);
            if ((PW+1)'(k) < older_cnt) begin
                if (!addr_ok[idx]) begin
                    stall = 1'b1;
                end else if (addrs[idx] == ld_addr) begin
                    hit     = 1'b1;
                    hit_idx = idx;
                end
            end
        end
    end

    always_comb begin
        resp     = LD_GO_MEM;
        fwd_data = '0;
        fwd_tag  = '0;
        if (ld_valid) begin
            if (stall) begin
                resp = LD_STALL;
            end else if (hit && data_ok[hit_idx]) begin
                resp     = LD_FWD_DATA;
                fwd_data = datas[hit_idx];
            end else if (hit) begin
                resp    = LD_FWD_TAG;
                fwd_tag = tags[hit_idx];
            end
        end
    end
endmodule

// File: rtl/store_queue.sv
module store_queue
    import stq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TW = 5,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [TW-1:0] alloc_src_tag,
    output logic          alloc_ready,
    output logic [PW:0]   alloc_pos,
    input  logic          st_addr_valid,
    input  logic [PW-1:0] st_addr_slot,
    input  logic [AW-1:0] st_addr,
    input  logic          st_data_valid,
    input  logic [PW-1:0] st_data_slot,
    input  logic [DW-1:0] st_data,
    input  logic          commit_valid,
    input  logic          flush,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [PW:0]   ld_pos,
    output logic [1:0]    ld_resp,
    output logic [DW-1:0] ld_data,
    output logic [TW-1:0] ld_tag,
    output logic          mem_wr_valid,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data
);
    logic [PW:0]              head_ptr, cmt_ptr, tail_ptr;
    logic                     full, alloc_fire, drain_fire;
    logic [DEPTH-1:0]         aok, dok;
    logic [DEPTH-1:0][AW-1:0] addrs;
    logic [DEPTH-1:0][DW-1:0] datas;
    logic [DEPTH-1:0][TW-1:0] tags;
    logic [PW-1:0]            hslot;
    ld_resp_e                 resp;

    assign hslot = head_ptr[PW-1:0];
    // Head leaves only once committed (head behind commit) with address and value known.
    assign drain_fire = (head_ptr != cmt_ptr) && aok[hslot] && dok[hslot];

    stq_pointers #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_valid), .commit_req(commit_valid), .flush(flush),
        .drain_fire(drain_fire),
        .head(head_ptr), .cmt(cmt_ptr), .tail(tail_ptr),
        .full(full), .alloc_fire(alloc_fire)
    );

    stq_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_ent (
        .clk(clk), .rst_n(rst_n),
        .alloc_fire(alloc_fire), .alloc_tag(alloc_src_tag),
        .addr_wr(st_addr_valid), .addr_slot(st_addr_slot), .addr_val(st_addr),
        .data_wr(st_data_valid), .data_slot(st_data_slot), .data_val(st_data),
        .drain_fire(drain_fire), .flush(flush),
        .head(head_ptr), .cmt(cmt_ptr), .tail(tail_ptr),
        .addr_ok(aok), .data_ok(dok), .addrs(addrs), .datas(datas), .tags(tags)
    );

    stq_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_srch (
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_pos(ld_pos), .head(head_ptr),
        .addr_ok(aok), .data_ok(dok), .addrs(addrs), .datas(datas), .tags(tags),
        .resp(resp), .fwd_data(ld_data), .fwd_tag(ld_tag)
    );

    assign ld_resp      = resp;
    assign alloc_ready  = ~full;
    assign alloc_pos    = tail_ptr;
    assign mem_wr_valid = drain_fire;
    assign mem_wr_addr  = addrs[hslot];
    assign mem_wr_data  = datas[hslot];
endmodule

// File: rtl/store_queue_checker.sv
module store_queue_checker #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        alloc_valid,
    input logic        alloc_ready,
    input logic        flush,
    input logic        mem_wr_valid,
    input logic        ld_valid,
    input logic [PW:0] ld_pos,
    input logic [1:0]  ld_resp,
    input logic [PW:0] head_ptr,
    input logic [PW:0] cmt_ptr,
    input logic [PW:0] tail_ptr
);
    logic [PW:0] occ, ccnt;
    assign occ  = tail_ptr - head_ptr;
    assign ccnt = cmt_ptr - head_ptr;

    a_r1_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |=> head_ptr == $past(head_ptr) + 1'b1);

    a_r2_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_ready && !flush) |=> tail_ptr == $past(tail_ptr));

    a_r2_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (PW+1)'(DEPTH));

    a_r10_write_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> head_ptr != cmt_ptr);

    a_r10_commit_within_queue: assert property (@(posedge clk) disable iff (!rst_n)
        ccnt <= occ);

    a_r11_flush_trims: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> tail_ptr == $past(cmt_ptr));

    a_r9_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_pos == head_ptr) |-> ld_resp == 2'd0);
endmodule

bind store_queue store_queue_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .flush(flush), .mem_wr_valid(mem_wr_valid), .ld_valid(ld_valid), .ld_pos(ld_pos),
    .ld_resp(ld_resp), .head_ptr(head_ptr), .cmt_ptr(cmt_ptr), .tail_ptr(tail_ptr)
);

// File: tb/sim_store_queue.sv
`timescale 1ns/1ps
module sim_store_queue;
    localparam int D = 8;
    localparam int P2 = 2 * D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0;
    logic [4:0]  alloc_src_tag = 0;
    logic        alloc_ready;
    logic [3:0]  alloc_pos;
    logic        st_addr_valid = 0;
    logic [2:0]  st_addr_slot = 0;
    logic [15:0] st_addr = 0;
    logic        st_data_valid = 0;
    logic [2:0]  st_data_slot = 0;
    logic [15:0] st_data = 0;
    logic        commit_valid = 0;
    logic        flush = 0;
    logic        ld_valid = 0;
    logic [15:0] ld_addr = 0;
    logic [3:0]  ld_pos = 0;
    logic [1:0]  ld_resp;
    logic [15:0] ld_data;
    logic [4:0]  ld_tag;
    logic        mem_wr_valid;
    logic [15:0] mem_wr_addr;
    logic [15:0] mem_wr_data;

    store_queue u0 (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R2";

    // Reference model: sequence numbers grow without bound; [h,t) are held, [h,c) committed.
    int h = 0, c = 0, t = 0;
    bit          m_aok[int];
    bit          m_dok[int];
    logic [15:0] m_addr[int];
    logic [15:0] m_data[int];
    logic [4:0]  m_tag[int];

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL [%s] %s act=%0d exp=%0d", cur_req, what, act, exp);
        end
    endtask

    function automatic bit exp_drain();
        return (h < c) && m_aok[h] && m_dok[h];
    endfunction

    task automatic compare();
        int ldseq, hit, resp;
        bit stall;
        chk("R2 alloc_ready", int'(alloc_ready), int'((t - h) < D));
        chk("R2 alloc_pos", int'(alloc_pos), t % P2);
        chk("R10 mem_wr_valid", int'(mem_wr_valid), int'(exp_drain()));
        if (exp_drain()) begin
            chk("R1 mem_wr_addr", int'(mem_wr_addr), int'(m_addr[h]));
            chk("R1 mem_wr_data", int'(mem_wr_data), int'(m_data[h]));
        end
        resp = 0;
        if (ld_valid) begin
            ldseq = t - (((t % P2) - int'(ld_pos) + P2) % P2);
            stall = 0; hit = -1;
            for (int s = h; s < ldseq; s++) begin
                if (!m_aok[s]) stall = 1;
                else if (m_addr[s] == ld_addr) hit = s;
            end
            if (stall) resp = 1;
            else if (hit >= 0 && m_dok[hit]) resp = 2;
            else if (hit >= 0) resp = 3;
            chk("ld_resp", int'(ld_resp), resp);
            if (resp == 2) chk("ld_data", int'(ld_data), int'(m_data[hit]));
            if (resp == 3) chk("ld_tag", int'(ld_tag), int'(m_tag[hit]));
        end else begin
            chk("R9 idle ld_resp", int'(ld_resp), 0);
        end
    endtask

    task automatic model_update();
        bit fa, fc, fd;
        fa = alloc_valid && !flush && ((t - h) < D);
        fc = commit_valid && !flush && (c < t);
        fd = exp_drain();
        for (int s = h; s < t; s++) begin
            if (st_addr_valid && (s % D) == int'(st_addr_slot)) begin
                m_addr[s] = st_addr; m_aok[s] = 1;
            end
            if (st_data_valid && (s % D) == int'(st_data_slot)) begin
                m_data[s] = st_data; m_dok[s] = 1;
            end
        end
        if (fd) h++;
        if (fc) c++;
        if (fa) begin
            m_aok[t] = 0; m_dok[t] = 0; m_tag[t] = alloc_src_tag;
            m_addr[t] = 0; m_data[t] = 0;
            t++;
        end
        if (flush) begin
            for (int s = c; s < t; s++) begin
                m_aok[s] = 0; m_dok[s] = 0;
            end
            t = c;
        end
    endtask

    task automatic tick();
        #1;
        compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        alloc_valid = 0; st_addr_valid = 0; st_data_valid = 0;
        commit_valid = 0; flush = 0; ld_valid = 0;
    endtask

    task automatic do_alloc(int tg);
        alloc_valid = 1; alloc_src_tag = 5'(tg);
    endtask
    task automatic do_addr(int slot, int a);
        st_addr_valid = 1; st_addr_slot = 3'(slot); st_addr = 16'(a);
    endtask
    task automatic do_data(int slot, int v);
        st_data_valid = 1; st_data_slot = 3'(slot); st_data = 16'(v);
    endtask
    task automatic do_load(int pos, int a);
        ld_valid = 1; ld_pos = 4'(pos); ld_addr = 16'(a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL [watchdog] run did not finish act=1 exp=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state and empty window (R2, R9)
        cur_req = "R9"; do_load(0, 16'h55); tick();
        // allocate three stores, tags 5,6,7 at slots 0..2 (R2)
        cur_req = "R2";
        for (int i = 0; i < 3; i++) begin do_alloc(5 + i); tick(); end
        // older addresses unknown (R5)
        cur_req = "R5"; do_load(3, 16'h100); tick();
        do_addr(0, 16'h100); do_load(3, 16'h100); tick();
        do_addr(1, 16'h200); do_load(3, 16'h100); tick();
        do_addr(2, 16'h100); tick();
        // two matches, youngest without value gives its tag (R7, R8)
        cur_req = "R8"; do_load(3, 16'h100); tick();
        cur_req = "R6"; do_data(2, 16'hBEEF); tick();
        do_load(3, 16'h100); tick();
        // window limited by ld_pos (R4)
        cur_req = "R4"; do_load(2, 16'h100); tick();
        do_load(1, 16'h200); tick();
        cur_req = "R9"; do_load(3, 16'h300); tick();
        // writes to empty slot 6 are dropped (R3)
        cur_req = "R3"; do_addr(6, 16'h300); do_data(6, 16'h1234); tick();
        for (int i = 0; i < 4; i++) begin do_alloc(10 + i); tick(); end
        do_load(7, 16'h300); tick();
        do_addr(3, 16'h400); tick();
        do_addr(4, 16'h401); tick();
        do_addr(5, 16'h402); tick();
        do_load(7, 16'h300); tick();
        do_addr(6, 16'h300); tick();
        do_load(7, 16'h300); tick();
        // commit gating and in-order drain (R10, R1)
        cur_req = "R10"; do_data(0, 16'h1111); tick();
        do_data(1, 16'h2222); tick();
        commit_valid = 1; tick();
        cur_req = "R1"; commit_valid = 1; tick();
        commit_valid = 1; tick();
        tick(); tick();
        // flush keeps committed, drops uncommitted, ignores alloc/commit (R11)
        cur_req = "R11"; commit_valid = 1; tick();
        flush = 1; do_alloc(20); tick();
        flush = 1; commit_valid = 1; tick();
        do_data(3, 16'h3333); do_load(4, 16'h400); tick();
        tick();
        // fill to full and overflow attempt (R2)
        cur_req = "R2";
        for (int i = 0; i < 9; i++) begin do_alloc(i); tick(); end
        // wrap-around age (R12): seqs 4..11 at slots 4..7,0..3
        cur_req = "R12";
        for (int s = 4; s < 12; s++) begin
            do_addr(s % D, (s == 5 || s == 10) ? 16'h777 : 16'h500 + s);
            do_data(s % D, 16'hA000 + s); tick();
        end
        do_load(12, 16'h777); tick();
        do_load(10, 16'h777); tick();
        do_load(5, 16'h777); tick();
        for (int i = 0; i < 8; i++) begin commit_valid = 1; tick(); end
        tick(); tick();
        for (int s = 12; s < 18; s++) begin do_alloc(s); tick(); end
        for (int s = 12; s < 18; s++) begin
            do_addr(s % D, (s == 13 || s == 16) ? 16'h888 : 16'h600 + s);
            if (s == 13) do_data(s % D, 16'hC0DE);
            tick();
        end
        do_load(2, 16'h888); tick();
        do_load(15, 16'h888); tick();
        do_load(13, 16'h888); tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule